// File: doc/BRIEF.md
# Transmit Delay and Break Timer

This block sits beside a serial transmitter and carries out delay commands that are embedded in the outgoing data stream. When the command parser presents a delay command, the block loads the command's period into a down counter. It then raises a hold that stops the transmitter from sending anything more. While the hold is up, it forces the serial line to a fixed level. The level is low for a send-break command and high for an inter-character fill command.

The counter moves down by one on each tick-enable pulse. Once it has reached zero, the hold and the line override drop on the next clock edge, and a one-cycle done pulse tells the command source to move on. Commands are acted on only while the embedded-command feature is enabled. A command with a zero period finishes at once, with no hold. Clearing the enable during a delay abandons the delay.

Top module: `txdly_timer`

## Requirements
- R1: During and directly after reset, `tx_hold` = 0, `line_force_en` = 0, `line_force_val` = 1 and `done` = 0.
- R2: A command accepted while idle (`cmd_valid` = 1, `embed_en` = 1, `tx_hold` = 0) with a non-zero `cmd_period` raises `tx_hold` and `line_force_en` on the next clock edge.
- R3: While the line is forced, `line_force_val` equals the accepted `cmd_kind` bit (0 = send break, line low; 1 = inter-character fill, line high), and it stays constant until the hold ends.
- R4: The counter is loaded with `cmd_period` and decrements only on edges where `tick_en` = 1. The hold ends on the edge after the count reaches zero, so it lasts until P ticks have been seen plus one more cycle.
- R5: `done` pulses high for exactly one cycle, in the same cycle in which `tx_hold` falls after a completed delay.
- R6: An accepted command with `cmd_period` = 0 gives `done` = 1 on the next edge and never raises `tx_hold`.
- R7: A command presented while `embed_en` = 0 is ignored: `tx_hold`, `line_force_en` and `done` stay 0.
- R8: A command presented while `tx_hold` = 1 is ignored: it neither reloads the counter nor changes the forced level.
- R9: If `embed_en` falls during a hold, `tx_hold` and `line_force_en` drop on the next edge and no `done` pulse is issued.
- R10: Whenever `line_force_en` = 0, `line_force_val` reads 1 (idle mark level).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Delay command strobe |
| cmd_kind | input | 1 | 0 = send break, 1 = inter-character fill |
| cmd_period | input | PERIOD_W | Delay length in ticks |
| embed_en | input | 1 | Embedded transmit command feature enable |
| tick_en | input | 1 | Timer tick enable |
| tx_hold | output | 1 | Blocks further transmission while high |
| line_force_val | output | 1 | Level to drive on the serial line |
| line_force_en | output | 1 | Line override active |
| done | output | 1 | One-cycle pulse when a delay completes |

## Verification
The bench builds the block with `PERIOD_W` = 4. At that width the largest period, 15, is within reach, and the counter can be run from its maximum value down to zero in a few dozen cycles. The vectors combine break and fill commands with tick spacings of one to three cycles, so the hold length P×gap+1 is checked against both the period and the tick rate. Directed runs then cover a zero period, a disabled feature, a command that arrives during a hold, and an enable that is cleared partway through a delay.

// File: rtl/txd_pkg.sv
package txd_pkg;
    typedef enum logic {
        KIND_BREAK = 1'b0,
        KIND_FILL  = 1'b1
    } txd_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } txd_state_e;

    typedef struct packed {
        txd_state_e st;
        logic       level;
        logic       done;
    } txd_ctrl_s;
endpackage

// File: rtl/txd_count.sv
module txd_count #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    input  logic         clear,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (load)
            cnt_d = load_val;
        else if (dec)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/txd_ctrl.sv
module txd_ctrl
    import txd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic cmd_kind,
    input  logic period_zero,
    input  logic embed_en,
    input  logic tick_en,
    input  logic cnt_zero,
    output logic load,
    output logic dec,
    output logic clear,
    output logic hold,
    output logic level,
    output logic done
);
    txd_ctrl_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        load      = 1'b0;
        dec       = 1'b0;
        clear     = 1'b0;
        unique case (st_q.st)
            ST_IDLE: begin
                if (cmd_valid && embed_en) begin
                    if (period_zero) begin
                        st_d.done = 1'b1;
                    end else begin
                        st_d.st    = ST_WAIT;
                        st_d.level = cmd_kind;
                        load       = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (!embed_en) begin
                    st_d.st    = ST_IDLE;
                    st_d.level = 1'b1;
                    clear      = 1'b1;
                end else if (cnt_zero) begin
                    st_d.st    = ST_IDLE;
                    st_d.level = 1'b1;
                    st_d.done  = 1'b1;
                end else begin
                    dec = tick_en;
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st    <= ST_IDLE;
            st_q.level <= 1'b1;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold  = (st_q.st == ST_WAIT);
    assign level = st_q.level;
    assign done  = st_q.done;
endmodule

// File: rtl/txdly_timer.sv
module txdly_timer #(
    parameter int unsigned PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic                cmd_kind,
    input  logic [PERIOD_W-1:0] cmd_period,
    input  logic                embed_en,
    input  logic                tick_en,
    output logic                tx_hold,
    output logic                line_force_val,
    output logic                line_force_en,
    output logic                done
);
    logic load, dec, clear, cnt_zero, hold, level;

    txd_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_kind    (cmd_kind),
        .period_zero (cmd_period == '0),
        .embed_en    (embed_en),
        .tick_en     (tick_en),
        .cnt_zero    (cnt_zero),
        .load        (load),
        .dec         (dec),
        .clear       (clear),
        .hold        (hold),
        .level       (level),
        .done        (done)
    );

    txd_count #(.W(PERIOD_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (cmd_period),
        .dec      (dec),
        .clear    (clear),
        .zero     (cnt_zero)
    );

    assign tx_hold        = hold;
    assign line_force_en  = hold;
    assign line_force_val = level;
endmodule

// File: rtl/txdly_timer_chk.sv
module txdly_timer_chk #(
    parameter int unsigned PERIOD_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic                cmd_kind,
    input logic [PERIOD_W-1:0] cmd_period,
    input logic                embed_en,
    input logic                tick_en,
    input logic                tx_hold,
    input logic                line_force_val,
    input logic                line_force_en,
    input logic                done
);
    logic accept;
    assign accept = cmd_valid && embed_en && !tx_hold;

    a_r2_hold_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_period != '0) |=> (tx_hold && line_force_en));

    a_r3_level_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_hold && $past(tx_hold)) |-> $stable(line_force_val));

    a_r4_no_tick_no_end: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_hold && !tick_en && embed_en && !$rose(tx_hold) && $past(tick_en) == 1'b0
         && $past(tx_hold)) |=> tx_hold || done);

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_done_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !tx_hold);

    a_r6_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_period == '0) |=> (done && !tx_hold));

    a_r7_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!embed_en && !tx_hold) |=> (!tx_hold && !done));

    a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_hold && !embed_en) |=> (!tx_hold && !done));

    a_r10_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
        !line_force_en |-> line_force_val);
endmodule

bind txdly_timer txdly_timer_chk #(.PERIOD_W(PERIOD_W)) i_chk (.*);

// File: tb/test_txdly_timer.sv
module test_txdly_timer;
    localparam int unsigned PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_kind = 1'b0;
    logic [PW-1:0] cmd_period = '0;
    logic          embed_en = 1'b0;
    logic          tick_en = 1'b0;
    logic          tx_hold, line_force_val, line_force_en, done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    txdly_timer #(.PERIOD_W(PW)) i_txdly_timer (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_period(cmd_period), .embed_en(embed_en), .tick_en(tick_en),
        .tx_hold(tx_hold), .line_force_val(line_force_val),
        .line_force_en(line_force_en), .done(done)
    );

    // {kind, period[3:0], gap[3:0]}
    localparam int NV = 6;
    localparam logic [8:0] VEC [NV] = '{
        {1'b0, 4'd3,  4'd1},
        {1'b1, 4'd5,  4'd1},
        {1'b0, 4'd2,  4'd3},
        {1'b1, 4'd1,  4'd1},
        {1'b1, 4'd0,  4'd1},
        {1'b0, 4'd15, 4'd2}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Issues one command and follows the hold until it ends.
    task automatic run(input logic kind, input int period, input int gap,
                       input int inject_k, input int drop_k,
                       output int holds, output int dones, output int lvl_bad,
                       output int done_after, output int val_after);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_kind   = kind;
        cmd_period = PW'(period);
        tick_en    = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        holds = 0; dones = 0; lvl_bad = 0;
        for (int k = 1; k < 300; k++) begin
            if (done) dones++;
            if (!tx_hold) break;
            holds++;
            if (line_force_en !== 1'b1 || line_force_val !== kind) lvl_bad++;
            tick_en = ((k % gap) == 0);
            if (k == inject_k) begin
                cmd_valid  = 1'b1;
                cmd_kind   = ~kind;
                cmd_period = '1;
            end else begin
                cmd_valid = 1'b0;
            end
            if (k == drop_k) embed_en = 1'b0;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        tick_en   = 1'b0;
        @(negedge clk);
        done_after = int'(done);
        val_after  = int'(line_force_val);
        embed_en   = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int holds, dones, lvl_bad, done_after, val_after, exp_h;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(tx_hold === 1'b0 && line_force_en === 1'b0 && line_force_val === 1'b1
              && done === 1'b0, "R1 in reset", int'({tx_hold, line_force_en, line_force_val, done}), 2);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_hold === 1'b0 && line_force_en === 1'b0 && line_force_val === 1'b1
              && done === 1'b0, "R1 after reset", int'({tx_hold, line_force_en, line_force_val, done}), 2);

        // R7 disabled feature ignores a command
        embed_en = 1'b0;
        cmd_valid = 1'b1; cmd_kind = 1'b0; cmd_period = 4'd4;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 6; i++) begin
            check(tx_hold === 1'b0 && line_force_en === 1'b0 && done === 1'b0,
                  "R7 disabled ignore", int'({tx_hold, line_force_en, done}), 0);
            @(negedge clk);
        end
        embed_en = 1'b1;

        // Vector table: R2 R3 R4 R5 R6 R10
        for (int v = 0; v < NV; v++) begin
            logic kind;
            int p, g;
            kind = VEC[v][8];
            p = int'(VEC[v][7:4]);
            g = int'(VEC[v][3:0]);
            run(kind, p, g, 0, 0, holds, dones, lvl_bad, done_after, val_after);
            exp_h = (p == 0) ? 0 : p * g + 1;
            if (p == 0)
                check(holds == 0, "R6 zero period no hold", holds, 0);
            else
                check(holds == exp_h, "R2/R4 hold length", holds, exp_h);
            check(lvl_bad == 0, "R3 forced level", lvl_bad, 0);
            check(dones == 1, "R5/R6 done at release", dones, 1);
            check(done_after == 0, "R5 done one cycle", done_after, 0);
            check(val_after == 1, "R10 idle mark", val_after, 1);
        end

        // R8 command during hold is ignored
        run(1'b0, 4, 1, 2, 0, holds, dones, lvl_bad, done_after, val_after);
        check(holds == 5, "R8 no reload during hold", holds, 5);
        check(lvl_bad == 0, "R8 level unchanged", lvl_bad, 0);
        check(dones == 1, "R8 single done", dones, 1);

        // R9 enable dropped mid-delay
        run(1'b1, 10, 1, 0, 3, holds, dones, lvl_bad, done_after, val_after);
        check(holds == 3, "R9 abort releases hold", holds, 3);
        check(dones == 0 && done_after == 0, "R9 no done on abort", dones + done_after, 0);
        check(val_after == 1 && line_force_en === 1'b0, "R9/R10 override off", val_after, 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule